// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Source Unit

This unit holds a fixed set of interrupt sources. Each source is built as either an edge source or a level source by a parameter bit mask. Every source has its own configuration: a target server and a priority. A priority of all ones (0xFF) masks the source. Edge sources take single-cycle pulses. Level sources follow a level input. The unit turns these events into delivery requests. Each request carries the target server, a global source number and the priority.

A presentation controller sits downstream and answers delivered interrupts. It can reject one, signal end of service for one, or ask for everything to be sent again. The unit keeps separate status for the two kinds of source so that nothing is lost:
- An edge source has a rejected bit and a masked-pending bit.
- A level source has an asserted bit and a sent bit.

Rejected or masked events are therefore replayed later. Global numbers are the local index plus a base offset, 4096 by default. Incoming reject and end-of-service numbers are mapped back by subtracting that offset. Requests leave through a valid/ready handshake, so only one request is held at the edge at a time. The resend operation walks the sources one per clock.

Top module: `irq_src_unit`

## Requirements
- R1: After reset every source has priority 0xFF (masked) and server 0, all status is clear, and `req_valid_o` is low. A pulse on a masked edge source then produces no request.
- R2: A pulse on an unmasked edge source produces a request whose server and priority are those configured and whose number is the local index plus `BASE_OFS`.
- R3: A pulse on a masked edge source sets its masked-pending bit. A later configuration write that gives the source a priority other than 0xFF clears the bit and produces exactly one request.
- R4: On a level source, a change of the level input is an evaluation event. If the source is unmasked, its input is high and its sent bit is clear, the unit sets sent and produces one request. A level that stays high produces no further request.
- R5: A reject for an edge source sets its rejected bit, and the next resend clears the bit and delivers again if the source is unmasked. A reject for a level source clears its sent bit, and the next resend delivers again if the input is still high.
- R6: An end-of-service for a level source clears its sent bit without producing a request by itself; a later resend redelivers while the input is high. An end-of-service for an edge source changes nothing.
- R7: A reject or end-of-service number below `BASE_OFS` or at or above `BASE_OFS + NUM_SRC` is ignored.
- R8: A resend visits source i in the i-th clock after the strobe, one source per clock. When several requests wait, the lowest local index leaves first.
- R9: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid and its server, number and priority do not change.
- R10: A configuration write to a level source is an evaluation event, so unmasking a source whose input is already high produces a request.
- R11: A configuration write that masks a source with a waiting, not yet issued request withdraws that request. An edge source keeps it as masked-pending; a level source clears sent. No request ever carries priority 0xFF.
- R12: The pulse input of a level source and the level input of an edge source have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | NUM_SRC | Level inputs, used by level sources |
| pulse_i | input | NUM_SRC | Single-cycle event inputs, used by edge sources |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Local index of the source to configure |
| cfg_server_i | input | SRV_W | New target server |
| cfg_prio_i | input | 8 | New priority, 0xFF masks |
| rej_valid_i | input | 1 | Reject strobe |
| rej_num_i | input | NUM_W | Global number being rejected |
| eoi_valid_i | input | 1 | End-of-service strobe |
| eoi_num_i | input | NUM_W | Global number whose service ended |
| resend_i | input | 1 | Start a resend walk over all sources |
| req_valid_o | output | 1 | Delivery request valid |
| req_ready_i | input | 1 | Delivery request accepted |
| req_server_o | output | SRV_W | Target server of the request |
| req_num_o | output | NUM_W | Global source number of the request |
| req_prio_o | output | 8 | Priority of the request |

## Verification
The assertions check the following on every cycle:
- the request stays stable while it is stalled;
- request numbers stay inside the unit's window;
- no request carries priority 0xFF;
- masked-pending bits exist only on masked sources;
- a sent bit rises only with the level asserted;
- the resend walk steps by one.

The replay behaviours can only be shown by the bench's ordered scenarios. These are reject followed by resend, end-of-service followed by resend, masked events released by a later configuration write, and withdrawal of a waiting request. The reference model compares the delivery port every clock across all of these.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

  typedef enum logic {SRC_EDGE = 1'b0, SRC_LEVEL = 1'b1} src_kind_e;

  typedef struct packed {
    logic rej;
    logic mpend;
    logic asrt;
    logic sent;
    logic queued;
  } src_st_t;
endpackage

// File: rtl/isu_num_decode.sv
module isu_num_decode #(
  parameter int NUM_SRC  = 8,
  parameter int NUM_W    = 16,
  parameter int BASE_OFS = 4096
) (
  input  logic               valid_i,
  input  logic [NUM_W-1:0]   num_i,
  output logic [NUM_SRC-1:0] hit_o
);
  localparam logic [NUM_W-1:0] BASE_L = NUM_W'(BASE_OFS);
  localparam logic [NUM_W-1:0] CNT_L  = NUM_W'(NUM_SRC);

  logic [NUM_W-1:0] diff;
  logic             in_rng;

  assign diff   = num_i - BASE_L;
  assign in_rng = valid_i && (num_i >= BASE_L) && (diff < CNT_L);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit_o[i] = in_rng && (diff == NUM_W'(i));
  end
endmodule

// File: rtl/isu_slice.sv
module isu_slice import isu_pkg::*; #(
  parameter src_kind_e KIND  = SRC_EDGE,
  parameter int        SRV_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              level_i,
  input  logic              pulse_i,
  input  logic              cfg_hit_i,
  input  logic [SRV_W-1:0]  cfg_server_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic              rej_hit_i,
  input  logic              eoi_hit_i,
  input  logic              scan_hit_i,
  input  logic              issued_i,
  output logic [SRV_W-1:0]  srv_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic              queued_o,
  output logic              sent_o,
  output logic              asrt_o,
  output logic              mpend_o
);
  logic [SRV_W-1:0]  srv_q;
  logic [PRIO_W-1:0] prio_q, prio_n;
  src_st_t           st_q, st_n;
  logic              masked_n, eval;

  always_comb begin
    prio_n    = cfg_hit_i ? cfg_prio_i : prio_q;
    masked_n  = (prio_n == PRIO_OFF);
    st_n      = st_q;
    st_n.queued = st_q.queued & ~issued_i;
    eval      = 1'b0;
    if (KIND == SRC_LEVEL) begin
      st_n.asrt = level_i;
      st_n.sent = st_q.sent & ~rej_hit_i & ~eoi_hit_i;
      // masking withdraws a waiting request
      if (cfg_hit_i && masked_n && st_n.queued) begin
        st_n.queued = 1'b0;
        st_n.sent   = 1'b0;
      end
      eval = (level_i != st_q.asrt) | cfg_hit_i | scan_hit_i;
      if (eval && !masked_n && level_i && !st_n.sent) begin
        st_n.sent   = 1'b1;
        st_n.queued = 1'b1;
      end
    end else begin
      st_n.rej = st_q.rej | rej_hit_i;
      if (cfg_hit_i && masked_n && st_n.queued) begin
        st_n.queued = 1'b0;
        st_n.mpend  = 1'b1;
      end
      if (pulse_i) begin
        if (masked_n) st_n.mpend  = 1'b1;
        else          st_n.queued = 1'b1;
      end
      if (cfg_hit_i && st_n.mpend && !masked_n) begin
        st_n.mpend  = 1'b0;
        st_n.queued = 1'b1;
      end
      if (scan_hit_i && st_n.rej) begin
        st_n.rej = 1'b0;
        if (!masked_n) st_n.queued = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srv_q  <= '0;
      prio_q <= PRIO_OFF;
      st_q   <= '0;
    end else begin
      st_q   <= st_n;
      prio_q <= prio_n;
      if (cfg_hit_i) srv_q <= cfg_server_i;
    end
  end

  assign srv_o    = srv_q;
  assign prio_o   = prio_q;
  assign queued_o = st_q.queued;
  assign sent_o   = st_q.sent;
  assign asrt_o   = st_q.asrt;
  assign mpend_o  = st_q.mpend;
endmodule

// File: rtl/isu_scan.sv
module isu_scan #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic [NUM_SRC-1:0] hit_o,
  output logic               act_o,
  output logic [IDX_W-1:0]   idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  logic             act_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      idx_q <= '0;
    end else if (act_q) begin
      if (idx_q == LAST) act_q <= 1'b0;
      else               idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit_o[i] = act_q && (idx_q == IDX_W'(i));
  end

  assign act_o = act_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/isu_issue.sv
module isu_issue import isu_pkg::*; #(
  parameter int NUM_SRC  = 8,
  parameter int SRV_W    = 4,
  parameter int NUM_W    = 16,
  parameter int BASE_OFS = 4096,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] queued_i,
  input  logic [SRV_W-1:0]   srv_i  [NUM_SRC],
  input  logic [PRIO_W-1:0]  prio_i [NUM_SRC],
  output logic [NUM_SRC-1:0] issued_o,
  output logic               valid_o,
  input  logic               ready_i,
  output logic [SRV_W-1:0]   server_o,
  output logic [NUM_W-1:0]   num_o,
  output logic [PRIO_W-1:0]  prio_o
);
  localparam logic [NUM_W-1:0] BASE_L = NUM_W'(BASE_OFS);

  logic [IDX_W-1:0]  sel;
  logic              load;
  logic              vld_q;
  logic [SRV_W-1:0]  srv_q;
  logic [NUM_W-1:0]  num_q;
  logic [PRIO_W-1:0] prio_q;

  always_comb begin
    sel = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (queued_i[i]) sel = IDX_W'(i);
    end
  end

  assign load     = (|queued_i) && (!vld_q || ready_i);
  assign issued_o = load ? (NUM_SRC'(1) << sel) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      srv_q  <= '0;
      num_q  <= '0;
      prio_q <= '0;
    end else if (load) begin
      vld_q  <= 1'b1;
      srv_q  <= srv_i[sel];
      num_q  <= BASE_L + NUM_W'(sel);
      prio_q <= prio_i[sel];
    end else if (ready_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign valid_o  = vld_q;
  assign server_o = srv_q;
  assign num_o    = num_q;
  assign prio_o   = prio_q;
endmodule

// File: rtl/irq_src_unit.sv
module irq_src_unit import isu_pkg::*; #(
  parameter int                 NUM_SRC    = 8,
  parameter int                 SRV_W      = 4,
  parameter int                 NUM_W      = 16,
  parameter int                 BASE_OFS   = 4096,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int                IDX_W      = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0] pulse_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [SRV_W-1:0]   cfg_server_i,
  input  logic [7:0]         cfg_prio_i,
  input  logic               rej_valid_i,
  input  logic [NUM_W-1:0]   rej_num_i,
  input  logic               eoi_valid_i,
  input  logic [NUM_W-1:0]   eoi_num_i,
  input  logic               resend_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [SRV_W-1:0]   req_server_o,
  output logic [NUM_W-1:0]   req_num_o,
  output logic [7:0]         req_prio_o
);
  logic [NUM_SRC-1:0] rej_hit, eoi_hit, scan_hit, issued;
  logic [NUM_SRC-1:0] queued_v, sent_v, asrt_v, mpend_v, masked_v;
  logic [SRV_W-1:0]   srv_a  [NUM_SRC];
  logic [PRIO_W-1:0]  prio_a [NUM_SRC];
  logic               scan_act;
  logic [IDX_W-1:0]   scan_idx;

  isu_num_decode #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE_OFS(BASE_OFS)) u_rej_dec (
    .valid_i(rej_valid_i), .num_i(rej_num_i), .hit_o(rej_hit)
  );

  isu_num_decode #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE_OFS(BASE_OFS)) u_eoi_dec (
    .valid_i(eoi_valid_i), .num_i(eoi_num_i), .hit_o(eoi_hit)
  );

  isu_scan #(.NUM_SRC(NUM_SRC)) u_scan (
    .clk_i, .rst_ni, .start_i(resend_i),
    .hit_o(scan_hit), .act_o(scan_act), .idx_o(scan_idx)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam src_kind_e KIND = LEVEL_MASK[i] ? SRC_LEVEL : SRC_EDGE;
    isu_slice #(.KIND(KIND), .SRV_W(SRV_W)) u_slice (
      .clk_i, .rst_ni,
      .level_i     (level_i[i]),
      .pulse_i     (pulse_i[i]),
      .cfg_hit_i   (cfg_we_i && (cfg_idx_i == IDX_W'(i))),
      .cfg_server_i(cfg_server_i),
      .cfg_prio_i  (cfg_prio_i),
      .rej_hit_i   (rej_hit[i]),
      .eoi_hit_i   (eoi_hit[i]),
      .scan_hit_i  (scan_hit[i]),
      .issued_i    (issued[i]),
      .srv_o       (srv_a[i]),
      .prio_o      (prio_a[i]),
      .queued_o    (queued_v[i]),
      .sent_o      (sent_v[i]),
      .asrt_o      (asrt_v[i]),
      .mpend_o     (mpend_v[i])
    );
    assign masked_v[i] = (prio_a[i] == PRIO_OFF);
  end

  isu_issue #(.NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE_OFS(BASE_OFS)) u_issue (
    .clk_i, .rst_ni,
    .queued_i(queued_v), .srv_i(srv_a), .prio_i(prio_a), .issued_o(issued),
    .valid_o(req_valid_o), .ready_i(req_ready_i),
    .server_o(req_server_o), .num_o(req_num_o), .prio_o(req_prio_o)
  );
endmodule

// File: rtl/isu_chk.sv
module isu_chk #(
  parameter int NUM_SRC  = 8,
  parameter int SRV_W    = 4,
  parameter int NUM_W    = 16,
  parameter int BASE_OFS = 4096,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_o,
  input logic               req_ready_i,
  input logic [SRV_W-1:0]   req_server_o,
  input logic [NUM_W-1:0]   req_num_o,
  input logic [7:0]         req_prio_o,
  input logic               resend_i,
  input logic [NUM_SRC-1:0] sent_v,
  input logic [NUM_SRC-1:0] asrt_v,
  input logic [NUM_SRC-1:0] mpend_v,
  input logic [NUM_SRC-1:0] masked_v,
  input logic               scan_act,
  input logic [IDX_W-1:0]   scan_idx
);
  localparam logic [NUM_W-1:0] LO = NUM_W'(BASE_OFS);
  localparam logic [NUM_W-1:0] HI = NUM_W'(BASE_OFS + NUM_SRC);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  a_r9_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_num_o)
      && $stable(req_prio_o) && $stable(req_server_o));

  a_r2_num_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_num_o >= LO) && (req_num_o < HI));

  a_r11_never_masked_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_prio_o != 8'hFF);

  a_r3_pending_only_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mpend_v & ~masked_v) == '0);

  a_r4_sent_needs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sent_v & ~$past(sent_v) & ~asrt_v) == '0);

  a_r8_scan_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_act && (scan_idx != LAST) && !resend_i |=> scan_act && (scan_idx == $past(scan_idx) + 1'b1));
endmodule

bind irq_src_unit isu_chk #(
  .NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE_OFS(BASE_OFS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
  .req_server_o(req_server_o), .req_num_o(req_num_o), .req_prio_o(req_prio_o),
  .resend_i(resend_i),
  .sent_v(sent_v), .asrt_v(asrt_v), .mpend_v(mpend_v), .masked_v(masked_v),
  .scan_act(scan_act), .scan_idx(scan_idx)
);

// File: tb/irq_src_unit_tb.sv
module irq_src_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int BASE = 4096;
  localparam logic [N-1:0] LVL = 8'hF0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] level = '0, pulse = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [3:0] cfg_srv = '0;
  logic [7:0] cfg_prio = '0;
  logic rej_v = 1'b0, eoi_v = 1'b0, resend = 1'b0, ready = 1'b1;
  logic [15:0] rej_num = '0, eoi_num = '0;
  logic req_valid;
  logic [3:0] req_srv;
  logic [15:0] req_num;
  logic [7:0] req_prio;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_src_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .level_i(level), .pulse_i(pulse),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_server_i(cfg_srv), .cfg_prio_i(cfg_prio),
    .rej_valid_i(rej_v), .rej_num_i(rej_num), .eoi_valid_i(eoi_v), .eoi_num_i(eoi_num),
    .resend_i(resend), .req_valid_o(req_valid), .req_ready_i(ready),
    .req_server_o(req_srv), .req_num_o(req_num), .req_prio_o(req_prio)
  );

  // reference model
  int m_prio[N], m_srv[N];
  bit m_q[N], m_mp[N], m_rej[N], m_sent[N], m_asr[N];
  bit m_vld, m_scan;
  int m_num, m_oprio, m_osrv, m_sidx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_prio[i] = 255; m_srv[i] = 0;
        m_q[i] = 0; m_mp[i] = 0; m_rej[i] = 0; m_sent[i] = 0; m_asr[i] = 0;
      end
      m_vld = 0; m_scan = 0; m_sidx = 0; m_num = 0; m_oprio = 0; m_osrv = 0;
    end else begin
      int iss;
      bit anyq;
      iss = -1; anyq = 0;
      for (int i = 0; i < N; i++) if (m_q[i]) anyq = 1;
      if (anyq && (!m_vld || ready)) begin
        for (int i = N - 1; i >= 0; i--) if (m_q[i]) iss = i;
        m_vld = 1; m_num = BASE + iss; m_oprio = m_prio[iss]; m_osrv = m_srv[iss];
      end else if (ready) m_vld = 0;
      for (int i = 0; i < N; i++) begin
        bit ch, msk, rh, eh, sh, q, ev;
        int pn;
        ch  = cfg_we && (int'(cfg_idx) == i);
        pn  = ch ? int'(cfg_prio) : m_prio[i];
        msk = (pn == 255);
        rh  = rej_v && (int'(rej_num) == BASE + i);
        eh  = eoi_v && (int'(eoi_num) == BASE + i);
        sh  = m_scan && (m_sidx == i);
        q   = m_q[i] && (iss != i);
        if (LVL[i]) begin
          bit s;
          s = m_sent[i] && !rh && !eh;
          if (ch && msk && q) begin q = 0; s = 0; end
          ev = (level[i] != m_asr[i]) || ch || sh;
          if (ev && !msk && level[i] && !s) begin s = 1; q = 1; end
          m_sent[i] = s; m_asr[i] = level[i];
        end else begin
          bit r, mp;
          r = m_rej[i] || rh; mp = m_mp[i];
          if (ch && msk && q) begin q = 0; mp = 1; end
          if (pulse[i]) begin if (msk) mp = 1; else q = 1; end
          if (ch && mp && !msk) begin mp = 0; q = 1; end
          if (sh && r) begin r = 0; if (!msk) q = 1; end
          m_rej[i] = r; m_mp[i] = mp;
        end
        m_q[i] = q;
        if (ch) begin m_prio[i] = int'(cfg_prio); m_srv[i] = int'(cfg_srv); end
      end
      if (resend) begin m_scan = 1; m_sidx = 0; end
      else if (m_scan) begin if (m_sidx == N - 1) m_scan = 0; else m_sidx++; end
    end
  end

  // per-clock comparison of the delivery port (R9, R2)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (req_valid !== m_vld) begin
        n_fail++;
        $display("FAIL R9 valid act=%0b exp=%0b t=%0t", req_valid, m_vld, $time);
      end else if (m_vld && (int'(req_num) != m_num || int'(req_prio) != m_oprio || int'(req_srv) != m_osrv)) begin
        n_fail++;
        $display("FAIL R2 fields act=%0d/%0d/%0d exp=%0d/%0d/%0d t=%0t",
                 req_num, req_prio, req_srv, m_num, m_oprio, m_osrv, $time);
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_req(string tag, int num, int pr, int srv);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (req_valid) break;
    end
    chk(req_valid === 1'b1, {tag, " valid"}, int'(req_valid), 1);
    chk(int'(req_num) == num, {tag, " num"}, int'(req_num), num);
    chk(int'(req_prio) == pr, {tag, " prio"}, int'(req_prio), pr);
    chk(int'(req_srv) == srv, {tag, " server"}, int'(req_srv), srv);
  endtask

  task automatic expect_none(string tag, int n);
    bit seen;
    seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (req_valid) seen = 1;
    end
    chk(!seen, {tag, " no request"}, int'(seen), 0);
  endtask

  task automatic cfg(int idx, int srv, int pr);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_srv = 4'(srv); cfg_prio = 8'(pr);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fire(logic [N-1:0] m);
    @(negedge clk); pulse = m;
    @(negedge clk); pulse = '0;
  endtask

  task automatic reject(int n);
    @(negedge clk); rej_v = 1; rej_num = 16'(n);
    @(negedge clk); rej_v = 0;
  endtask

  task automatic eoi(int n);
    @(negedge clk); eoi_v = 1; eoi_num = 16'(n);
    @(negedge clk); eoi_v = 0;
  endtask

  task automatic do_resend();
    @(negedge clk); resend = 1;
    @(negedge clk); resend = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_valid === 1'b0, "R1 reset valid", int'(req_valid), 0);
    fire(8'h01);                                 // R1: src0 masked after reset
    expect_none("R1 masked pulse", 6);
    cfg(0, 3, 5);                                // R3: unmask releases pending
    expect_req("R3 release", BASE, 5, 3);
    expect_none("R3 single", 6);
    cfg(1, 1, 2);
    fire(8'h02);                                 // R2
    expect_req("R2 edge", BASE + 1, 2, 1);
    cfg(2, 2, 6);
    // R9 / R8: stall, two waiting, lowest first
    @(negedge clk); ready = 0;
    fire(8'h06);
    repeat (4) @(negedge clk);
    chk(req_valid && int'(req_num) == BASE + 1, "R9 held num", int'(req_num), BASE + 1);
    chk(int'(req_prio) == 2, "R9 held prio", int'(req_prio), 2);
    ready = 1;
    expect_req("R8 second", BASE + 2, 6, 2);
    // R11: withdraw a waiting request by masking
    @(negedge clk); ready = 0;
    fire(8'h02);
    fire(8'h04);
    cfg(2, 2, 255);
    @(negedge clk); ready = 1;
    expect_none("R11 withdrawn", 6);
    cfg(2, 2, 6);
    expect_req("R11 replay", BASE + 2, 6, 2);
    // R4 level
    cfg(4, 5, 7);
    @(negedge clk); level[4] = 1;
    expect_req("R4 level rise", BASE + 4, 7, 5);
    expect_none("R4 held high", 8);
    // R6 / R5 on level
    eoi(BASE + 4);
    expect_none("R6 eoi alone", 6);
    do_resend();
    expect_req("R6 resend after eoi", BASE + 4, 7, 5);
    expect_none("R6 scan tail", 10);
    reject(BASE + 4);
    do_resend();
    expect_req("R5 level reject", BASE + 4, 7, 5);
    expect_none("R5 scan tail", 10);
    // R5 / R6 on edge
    reject(BASE + 1);
    do_resend();
    expect_req("R5 edge reject", BASE + 1, 2, 1);
    expect_none("R5 edge tail", 10);
    eoi(BASE + 1);
    do_resend();
    expect_none("R6 edge eoi", 14);
    // R7 out of range
    reject(BASE + 8);
    eoi(BASE - 1);
    do_resend();
    expect_none("R7 ignored", 14);
    // R10 level cfg re-evaluation
    @(negedge clk); level[5] = 1;
    expect_none("R10 masked level", 5);
    cfg(5, 0, 3);
    expect_req("R10 cfg eval", BASE + 5, 3, 0);
    // R12 cross inputs
    fire(8'h10);
    @(negedge clk); level[0] = 1;
    expect_none("R12 ignored", 6);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule